// File: doc/BRIEF.md
# MCTP-over-SMBus Packet Transmitter

This block turns one management-transport packet request into the byte sequence of an SMBus block write. A request is made with a one-cycle start strobe. The strobe carries these fields:

- the target slave address and the block's own 7-bit slave address;
- the destination and source endpoint identifiers;
- the start-of-message and end-of-message markers;
- a 3-bit tag field (the tag-owner bit and the tag);
- the payload length.

On that strobe the block captures all of these fields. It then presents the frame one byte at a time on a valid/ready byte stream toward an SMBus master. The frame is eight header bytes, then the payload, then a packet error code. Payload bytes come from an upstream valid/ready stream and pass straight through to the output.

A 2-bit rolling sequence number is stamped into each packet, and it advances once for every packet that is accepted. A control-response request always goes out as a single packet, with both message markers set. A request whose length is zero or above the limit is not sent. For such a request the block stays idle and raises a one-cycle bus-release pulse. A one-cycle done pulse follows the last byte of every packet that is sent.

Top module: `mctp_smb_tx`

## Requirements
- R1: Frame byte 0 is the target address input with bit 0 forced to 0 (write direction).
- R2: Frame byte 1 is the command code 0x0F.
- R3: Frame byte 2 is the payload length plus 5.
- R4: Frame byte 3 is the own 7-bit address in bits 7:1, with bit 0 set to 1.
- R5: Frame bytes 4 to 7 are, in order:
  - the header version 0x01;
  - the destination endpoint ID;
  - the source endpoint ID;
  - a flags byte: start marker in bit 7, end marker in bit 6, sequence number in bits 5:4, bit 3 zero, tag field in bits 2:0.
- R6: The sequence number is the low 2 bits of a counter that is 0 after reset. The counter advances by one for each accepted packet and wraps from 3 to 0. Rejected requests leave it unchanged.
- R7: Payload bytes follow byte 7 in arrival order, for exactly the requested length. A byte moves only on a cycle where valid and ready are both high. While a header or error-code byte is stalled, it stays valid and unchanged.
- R8: The final byte is a CRC-8 (polynomial x^8+x^2+x+1, initial value 0) over all preceding frame bytes, starting from byte 0. The last flag is high on this byte and on no other.
- R9: When the control-response input is high at start, the flags byte has both bit 7 and bit 6 set, whatever the marker inputs are.
- R10: A start with length 0 or above 250 sends no byte. It gives a one-cycle release pulse in the cycle after the start, and the block stays idle.
- R11: Done pulses for exactly one cycle, in the cycle after the error-code byte is accepted. Idle is high whenever no packet is in progress. A start while a packet is in progress is ignored.
- R12: After reset, idle is high, and output valid, done and release are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe, sampled only when idle |
| ctrl_rsp_i | input | 1 | Request is a control response (forces both markers) |
| dest_addr_i | input | 8 | Target slave address byte |
| own_addr_i | input | 7 | Own 7-bit slave address |
| dest_eid_i | input | 8 | Destination endpoint ID |
| src_eid_i | input | 8 | Source endpoint ID |
| som_i | input | 1 | Start-of-message marker |
| eom_i | input | 1 | End-of-message marker |
| tag_i | input | 3 | Tag-owner bit and message tag |
| pay_len_i | input | 8 | Payload length in bytes |
| pay_valid_i | input | 1 | Upstream payload byte valid |
| pay_data_i | input | 8 | Upstream payload byte |
| pay_ready_o | output | 1 | Payload byte taken |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output frame byte |
| out_last_o | output | 1 | Output byte is the error-code byte |
| out_ready_i | input | 1 | SMBus master accepts the byte |
| done_o | output | 1 | One-cycle pulse after a packet ends |
| rel_o | output | 1 | One-cycle pulse after a rejected request |
| idle_o | output | 1 | No packet in progress |

## Verification
The embedded properties check, on every cycle:
- stalled header and error-code bytes stay valid and unchanged;
- the write bit of the first byte is clear;
- the last flag is only raised on a valid byte;
- done and release are single-cycle pulses that only appear while idle;
- the sequence counter has moved exactly once by the end of each packet.

Only the bench's scenarios can show the full byte content of each frame: the byte count, the endpoint fields, the flags layout, the payload order under stalls from both sides, and the CRC value. The same goes for sequence wrap-around, the forced markers of a control response, rejection of length 0 and 251, and a start that arrives mid-packet.

// File: rtl/mctp_tx_pkg.sv
// Package: shared types, constants and the CRC-8 step for the packet transmitter.
// Assumes byte-wide frame fields throughout.
package mctp_tx_pkg;

    localparam int BYTE_W   = 8;
    localparam int HDR_LEN  = 8;
    localparam int HDR_IW   = $clog2(HDR_LEN);

    // Fields captured at start; held for the whole packet.
    typedef struct packed {
        logic [7:0] dest_addr;
        logic [6:0] own_addr;
        logic [7:0] dest_eid;
        logic [7:0] src_eid;
        logic       som;
        logic       eom;
        logic [1:0] seq;
        logic [2:0] tag;
        logic [7:0] len;
    } tx_fields_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HDR  = 2'd1,
        S_PAY  = 2'd2,
        S_PEC  = 2'd3
    } tx_state_t;

    // One byte of CRC-8, polynomial 0x07, MSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] x;
        x = c ^ d;
        for (int i = 0; i < 8; i++) begin
            x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
        end
        return x;
    endfunction

endpackage

// File: rtl/mctp_tx_hdr.sv
// Module: header byte selector. Picks one of the eight header bytes from the
// captured fields by index. Purely combinational; assumes idx < 8.
module mctp_tx_hdr
    import mctp_tx_pkg::*;
#(
    parameter logic [7:0] CMD_CODE = 8'h0F,
    parameter logic [7:0] HDR_VER  = 8'h01
) (
    input  tx_fields_t        fld_i,
    input  logic [HDR_IW-1:0] idx_i,
    output logic [7:0]        byte_o
);

    logic [7:0] flags;

    // Assemble the flags byte: markers, sequence, reserved zero, tag.
    always_comb begin
        flags = {fld_i.som, fld_i.eom, fld_i.seq, 1'b0, fld_i.tag};
    end

    // Select the header byte for this index.
    always_comb begin
        case (idx_i)
            3'd0:    byte_o = {fld_i.dest_addr[7:1], 1'b0};
            3'd1:    byte_o = CMD_CODE;
            3'd2:    byte_o = fld_i.len + 8'd5;
            3'd3:    byte_o = {fld_i.own_addr, 1'b1};
            3'd4:    byte_o = HDR_VER;
            3'd5:    byte_o = fld_i.dest_eid;
            3'd6:    byte_o = fld_i.src_eid;
            default: byte_o = flags;
        endcase
    end

endmodule

// File: rtl/mctp_tx_pec.sv
// Module: running packet error code. Clears on a new packet and folds in each
// accepted byte. Assumes clr and upd are never high together.
module mctp_tx_pec
    import mctp_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       upd_i,
    input  logic [7:0] din_i,
    output logic [7:0] crc_o
);

    logic [7:0] crc_q;

    // Hold the CRC: zero on reset or clear, advance on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            crc_q <= 8'h00;
        end else if (upd_i) begin
            crc_q <= crc8_step(crc_q, din_i);
        end
    end

    assign crc_o = crc_q;

endmodule

// File: rtl/mctp_smb_tx.sv
// Module: packet transmitter top. Captures a request on start, then streams
// eight header bytes, the payload (passed through from upstream) and the CRC
// byte. Assumes the SMBus master takes bytes on valid&ready, and that the
// payload source supplies exactly the requested length.
module mctp_smb_tx
    import mctp_tx_pkg::*;
#(
    parameter int PAY_MAX = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       ctrl_rsp_i,
    input  logic [7:0] dest_addr_i,
    input  logic [6:0] own_addr_i,
    input  logic [7:0] dest_eid_i,
    input  logic [7:0] src_eid_i,
    input  logic       som_i,
    input  logic       eom_i,
    input  logic [2:0] tag_i,
    input  logic [7:0] pay_len_i,
    input  logic       pay_valid_i,
    input  logic [7:0] pay_data_i,
    output logic       pay_ready_o,
    output logic       out_valid_o,
    output logic [7:0] out_data_o,
    output logic       out_last_o,
    input  logic       out_ready_i,
    output logic       done_o,
    output logic       rel_o,
    output logic       idle_o
);

    localparam logic [HDR_IW-1:0] HDR_LAST = HDR_IW'(HDR_LEN - 1);

    tx_state_t  state_q;
    tx_fields_t fld_q;
    logic [7:0] idx_q;
    logic [1:0] seq_q;
    logic       done_q;
    logic       rel_q;

    logic       len_ok;
    logic       start_acc;
    logic       start_rej;
    logic       hs;
    logic [7:0] hdr_byte;
    logic [7:0] crc;

    // Classify a start: accepted, rejected for length, or ignored while busy.
    always_comb begin
        len_ok    = (pay_len_i != 8'd0) && (int'(pay_len_i) <= PAY_MAX);
        start_acc = start_i && (state_q == S_IDLE) && len_ok;
        start_rej = start_i && (state_q == S_IDLE) && !len_ok;
    end

    mctp_tx_hdr u_hdr (
        .fld_i  (fld_q),
        .idx_i  (idx_q[HDR_IW-1:0]),
        .byte_o (hdr_byte)
    );

    mctp_tx_pec u_pec (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (start_acc),
        .upd_i (hs && (state_q != S_PEC)),
        .din_i (out_data_o),
        .crc_o (crc)
    );

    // Drive the output byte stream from the current phase.
    always_comb begin
        out_valid_o = 1'b0;
        out_data_o  = 8'h00;
        pay_ready_o = 1'b0;
        case (state_q)
            S_HDR: begin
                out_valid_o = 1'b1;
                out_data_o  = hdr_byte;
            end
            S_PAY: begin
                out_valid_o = pay_valid_i;
                out_data_o  = pay_data_i;
                pay_ready_o = out_ready_i;
            end
            S_PEC: begin
                out_valid_o = 1'b1;
                out_data_o  = crc;
            end
            default: ;
        endcase
        out_last_o = (state_q == S_PEC);
        hs         = out_valid_o && out_ready_i;
    end

    // Sequence the packet phases, capture fields and advance the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            fld_q   <= '0;
            idx_q   <= 8'd0;
            seq_q   <= 2'd0;
            done_q  <= 1'b0;
            rel_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            rel_q  <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start_acc) begin
                        fld_q.dest_addr <= dest_addr_i;
                        fld_q.own_addr  <= own_addr_i;
                        fld_q.dest_eid  <= dest_eid_i;
                        fld_q.src_eid   <= src_eid_i;
                        fld_q.som       <= som_i | ctrl_rsp_i;
                        fld_q.eom       <= eom_i | ctrl_rsp_i;
                        fld_q.seq       <= seq_q;
                        fld_q.tag       <= tag_i;
                        fld_q.len       <= pay_len_i;
                        seq_q           <= seq_q + 2'd1;
                        idx_q           <= 8'd0;
                        state_q         <= S_HDR;
                    end else if (start_rej) begin
                        rel_q <= 1'b1;
                    end
                end
                S_HDR: begin
                    if (hs) begin
                        if (idx_q[HDR_IW-1:0] == HDR_LAST) begin
                            idx_q   <= 8'd0;
                            state_q <= S_PAY;
                        end else begin
                            idx_q <= idx_q + 8'd1;
                        end
                    end
                end
                S_PAY: begin
                    if (hs) begin
                        if (idx_q == fld_q.len - 8'd1) begin
                            state_q <= S_PEC;
                        end else begin
                            idx_q <= idx_q + 8'd1;
                        end
                    end
                end
                default: begin
                    if (hs) begin
                        state_q <= S_IDLE;
                        done_q  <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign done_o = done_q;
    assign rel_o  = rel_q;
    assign idle_o = (state_q == S_IDLE);

    // R7
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_PAY && out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

    // R1
    wr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HDR && idx_q == 8'd0) |-> !out_data_o[0]);

    // R8
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last_o |-> out_valid_o);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> idle_o);

    // R10
    rel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_o |-> (idle_o && !done_o && !out_valid_o));

    // R6
    seq_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (seq_q == fld_q.seq + 2'd1));

endmodule

// File: tb/tb_mctp_smb_tx.sv
// Bench: table of packet requests walked by one loop, then directed tests
// for reset, rejected lengths, mid-packet start and sequence wrap.
module tb_mctp_smb_tx;

    typedef struct packed {
        logic [7:0] dest;
        logic [6:0] own;
        logic [7:0] deid;
        logic [7:0] seid;
        logic       som;
        logic       eom;
        logic [2:0] tag;
        logic [7:0] len;
        logic       ctrl;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{8'hA4, 7'h1D, 8'h09, 8'h08, 1'b1, 1'b1, 3'd3, 8'd1,   1'b0},
        '{8'h31, 7'h7F, 8'hFF, 8'h00, 1'b1, 1'b0, 3'd5, 8'd17,  1'b0},
        '{8'h00, 7'h00, 8'h10, 8'h20, 1'b0, 1'b0, 3'd0, 8'd64,  1'b0},
        '{8'hFF, 7'h55, 8'h33, 8'h44, 1'b0, 1'b1, 3'd7, 8'd250, 1'b0},
        '{8'h42, 7'h12, 8'h09, 8'h0A, 1'b0, 1'b0, 3'd2, 8'd6,   1'b1},
        '{8'h10, 7'h40, 8'h01, 8'h02, 1'b1, 1'b0, 3'd1, 8'd5,   1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, ctrl_rsp_i = 1'b0, som_i = 1'b0, eom_i = 1'b0;
    logic [7:0] dest_addr_i = '0, dest_eid_i = '0, src_eid_i = '0, pay_len_i = '0, pay_data_i = '0;
    logic [6:0] own_addr_i = '0;
    logic [2:0] tag_i = '0;
    logic pay_valid_i = 1'b0, out_ready_i = 1'b0;
    logic pay_ready_o, out_valid_o, out_last_o, done_o, rel_o, idle_o;
    logic [7:0] out_data_o;

    int checks = 0;
    int fails = 0;
    int exp_seq = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    mctp_smb_tx dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctrl_rsp_i(ctrl_rsp_i),
        .dest_addr_i(dest_addr_i), .own_addr_i(own_addr_i), .dest_eid_i(dest_eid_i),
        .src_eid_i(src_eid_i), .som_i(som_i), .eom_i(eom_i), .tag_i(tag_i),
        .pay_len_i(pay_len_i), .pay_valid_i(pay_valid_i), .pay_data_i(pay_data_i),
        .pay_ready_o(pay_ready_o), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
        .out_last_o(out_last_o), .out_ready_i(out_ready_i), .done_o(done_o),
        .rel_o(rel_o), .idle_o(idle_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Bit-serial CRC-8, polynomial 0x07.
    function automatic logic [7:0] crc_bits(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        logic fb;
        r = c;
        for (int b = 7; b >= 0; b--) begin
            fb = r[7] ^ d[b];
            r  = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return r;
    endfunction

    function automatic logic [7:0] pl(input int vi, input int i);
        return 8'(vi * 37 + i * 11 + 5);
    endfunction

    task automatic run_pkt(input vec_t v, input int vi, input bit poke);
        logic [7:0] exp [0:258];
        logic [7:0] c;
        int n;
        int got;
        int pidx;
        int cyc;
        int bad_last;
        n = int'(v.len) + 9;
        exp[0] = {v.dest[7:1], 1'b0};
        exp[1] = 8'h0F;
        exp[2] = v.len + 8'd5;
        exp[3] = {v.own, 1'b1};
        exp[4] = 8'h01;
        exp[5] = v.deid;
        exp[6] = v.seid;
        exp[7] = {v.som | v.ctrl, v.eom | v.ctrl, 2'(exp_seq), 1'b0, v.tag};
        for (int i = 0; i < int'(v.len); i++) exp[8 + i] = pl(vi, i);
        c = 8'h00;
        for (int i = 0; i < n - 1; i++) c = crc_bits(c, exp[i]);
        exp[n - 1] = c;
        @(negedge clk);
        dest_addr_i = v.dest; own_addr_i = v.own; dest_eid_i = v.deid; src_eid_i = v.seid;
        som_i = v.som; eom_i = v.eom; tag_i = v.tag; pay_len_i = v.len; ctrl_rsp_i = v.ctrl;
        start_i = 1'b1;
        got = 0; pidx = 0; cyc = 0; bad_last = 0;
        while (got < n && cyc < 2000) begin
            @(negedge clk);
            out_ready_i = (cyc % 3 != 1);
            pay_valid_i = (cyc % 4 != 2);
            pay_data_i  = pl(vi, pidx);
            if (poke && cyc == 4) begin
                start_i = 1'b1; dest_addr_i = 8'h6E; pay_len_i = 8'd3; som_i = ~v.som;
            end else begin
                start_i = 1'b0;
            end
            #1;
            if (cyc == 5 && poke) chk("R11 start ignored while busy", idle_o, 0);
            if (out_valid_o && out_ready_i) begin
                if (got == 0)      chk("R1 address byte", out_data_o, exp[got]);
                else if (got == 1) chk("R2 command byte", out_data_o, exp[got]);
                else if (got == 2) chk("R3 byte count", out_data_o, exp[got]);
                else if (got == 3) chk("R4 source address", out_data_o, exp[got]);
                else if (got < 8)  chk("R5 transport header", out_data_o, exp[got]);
                else if (got < n - 1) chk("R7 payload byte", out_data_o, exp[got]);
                else chk("R8 PEC byte", out_data_o, exp[got]);
                if (got == 7) begin
                    chk("R6 sequence field", out_data_o[5:4], exp_seq % 4);
                    if (v.ctrl) chk("R9 control markers", out_data_o[7:6], 3);
                end
                if (out_last_o != (got == n - 1)) bad_last++;
                got++;
            end
            if (pay_valid_i && pay_ready_o) pidx++;
            cyc++;
        end
        chk("R7 byte count delivered", got, n);
        chk("R8 last flag placement", bad_last, 0);
        chk("R7 payload consumed", pidx, int'(v.len));
        @(negedge clk);
        out_ready_i = 1'b0; pay_valid_i = 1'b0;
        #1;
        chk("R11 done after PEC", {done_o, idle_o}, 2'b11);
        @(negedge clk);
        #1;
        chk("R11 done one cycle", done_o, 0);
        exp_seq++;
    endtask

    task automatic reject(input logic [7:0] len);
        @(negedge clk);
        pay_len_i = len; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        #1;
        chk("R10 release pulse", {rel_o, idle_o, out_valid_o}, 3'b110);
        @(negedge clk);
        #1;
        chk("R10 release ends, nothing sent", {rel_o, out_valid_o, done_o}, 3'b000);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R12 reset outputs", {idle_o, out_valid_o, done_o, rel_o}, 4'b1000);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R12 state after reset", {idle_o, out_valid_o, done_o, rel_o}, 4'b1000);

        for (int k = 0; k < NVEC; k++) run_pkt(VECS[k], k, 1'b0);

        // R10: zero and over-limit lengths, then sequence must be unchanged (R6).
        reject(8'd0);
        reject(8'd251);
        run_pkt(VECS[1], 1, 1'b0);

        // R11: start arriving mid-packet is ignored.
        run_pkt(VECS[2], 2, 1'b1);
        run_pkt(VECS[0], 0, 1'b0);

        // R12: reset mid-packet returns to idle with sequence zero.
        @(negedge clk);
        pay_len_i = 8'd4; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R12 reset mid-packet", {idle_o, out_valid_o}, 2'b10);
        exp_seq = 0;
        run_pkt(VECS[5], 5, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule